// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes a 32-bit instruction word from the trap path and decodes it as a floating-point operate instruction. It first sorts the word into one of two operate formats, or rejects it. It looks up the 9-bit operation code to find the precision of each operand and the trap class the operation is expected under. It then turns the destination and the two source specifiers into 6-bit physical register indices. Double and quad operands fold the lowest specifier bit into the bank-select bit of the index. A quad specifier that is not aligned to four registers is refused.

The block also works out the new value of the 3-bit trap-type status field. On a successful decode the field is cleared. On a misaligned quad register it is set to the invalid-register code, 6. On any other rejection it is left as it was. Each source that lives in a register bank not yet marked dirty is flagged as reading zero. A compare operation has no destination register: it names one of four condition-code fields instead. The result is registered and appears one cycle after the input strobe.

Top module: `fp_opdecode`

## Requirements
- R1: A word whose bits {31,30,24:19} equal {1,0,110100} is format 1; with {1,0,110101} it is format 2 and `is_fmt2` is 1. Any other word gives error code 1.
- R2: `opf` reports insn[13:5] for every accepted strobe. The rd, rs1 and rs2 specifiers come from insn[29:25], insn[18:14] and insn[4:0]. Size codes: 0 none, 1 single, 2 double, 3 quad.
- R3: For a single-precision operand, the index is the 5-bit specifier zero-extended.
- R4: For a double or quad operand, the index is {spec[0], spec[4:1], 0}.
- R5: A quad operand whose specifier has bit 1 set gives error code 4 and trap-type output 6. All size codes, indices, zero flags and the compare flag are then 0.
- R6: Quad operations expect trap type 3, and single/double arithmetic and conversions expect 2. Square root of single or double accepts any value. Unless `via_illegal` is 1, a mismatch gives error code 3 and leaves the trap type unchanged.
- R7: A successful decode gives error code 0 and trap-type output 0.
- R8: An operation code not listed for its format gives error code 2, with all size codes 0 and the trap type unchanged.
- R9: After a successful decode, a source with a nonzero size is flagged zero when the dirty bit of its bank (`bank_dirty[0]` for indices below 32, `bank_dirty[1]` otherwise) is clear.
- R10: A quad compare (format 2, opf 0x053 or 0x057) sets `cc_dest`, reports rd[1:0] on `cc_sel` and gives a destination size of 0.
- R11: `out_valid` follows `in_valid` by one clock cycle. All other outputs hold their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode strobe |
| insn | input | 32 | Instruction word |
| tt_in | input | 3 | Current trap-type status field |
| via_illegal | input | 1 | Trap arrived as illegal instruction; skip class check |
| bank_dirty | input | 2 | Dirty flags of lower and upper register banks |
| out_valid | output | 1 | Result strobe |
| err_code | output | 3 | 0 ok, 1 not operate, 2 unknown opf, 3 class mismatch, 4 bad register |
| is_fmt2 | output | 1 | Word matched format 2 |
| opf | output | 9 | Operation code field |
| tt_out | output | 3 | New trap-type status field |
| rd_size | output | 2 | Destination size code |
| rs1_size | output | 2 | First source size code |
| rs2_size | output | 2 | Second source size code |
| rd_idx | output | 6 | Destination physical index |
| rs1_idx | output | 6 | First source physical index |
| rs2_idx | output | 6 | Second source physical index |
| rs1_zero | output | 1 | First source reads as zero |
| rs2_zero | output | 1 | Second source reads as zero |
| cc_dest | output | 1 | Destination is a condition-code field |
| cc_sel | output | 2 | Condition-code field select |

## Verification
The assertions assume that `tt_in` is stable in the cycle where the strobe is taken. This matters because the class-mismatch check compares the output trap type with the value sampled one cycle earlier. They also assume that the strobe is only raised after the internal reset synchronizer has released. To stay inside these assumptions, the stimulus changes every input only on the falling edge and waits several cycles after reset before its first strobe. Error paths that clear the operand outputs, and those that keep the trap type, are checked by properties keyed on the error code. The stimulus covers each error code at least once.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_SGL  = 2'd1,
    SZ_DBL  = 2'd2,
    SZ_QUAD = 2'd3
  } opnd_size_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NOT_FPOP = 3'd1,
    ERR_BAD_OPF  = 3'd2,
    ERR_CLASS    = 3'd3,
    ERR_BAD_REG  = 3'd4
  } dec_err_e;

  localparam logic [2:0] TT_CLR     = 3'd0;
  localparam logic [2:0] TT_SUBNORM = 3'd2;
  localparam logic [2:0] TT_QUADOP  = 3'd3;
  localparam logic [2:0] TT_BADREG  = 3'd6;

  typedef struct packed {
    logic       known;
    opnd_size_e rd_sz;
    opnd_size_e rs1_sz;
    opnd_size_e rs2_sz;
    logic [2:0] want_tt;
    logic       any_tt;
    logic       cmp;
  } op_info_t;

  function automatic op_info_t op_row(opnd_size_e d, opnd_size_e a,
                                      opnd_size_e b, logic [2:0] tt,
                                      logic any, logic cmp);
    op_info_t r;
    r.known   = 1'b1;
    r.rd_sz   = d;
    r.rs1_sz  = a;
    r.rs2_sz  = b;
    r.want_tt = tt;
    r.any_tt  = any;
    r.cmp     = cmp;
    return r;
  endfunction

endpackage

// File: rtl/fpdec_opmap.sv
module fpdec_opmap
  import fpdec_pkg::*;
#(
  parameter int OPF_W = 9
) (
  input  logic             is_fmt2,
  input  logic [OPF_W-1:0] opf,
  output op_info_t         info
);

  always_comb begin
    info = '0;
    if (!is_fmt2) begin
      case (opf)
        9'h003, 9'h007, 9'h00b: info = op_row(SZ_QUAD, SZ_NONE, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h02b:                 info = op_row(SZ_QUAD, SZ_NONE, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h043, 9'h047,
        9'h04b, 9'h04f:         info = op_row(SZ_QUAD, SZ_QUAD, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h06e:                 info = op_row(SZ_QUAD, SZ_DBL,  SZ_DBL,  TT_QUADOP, 1'b0, 1'b0);
        9'h083:                 info = op_row(SZ_DBL,  SZ_NONE, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h08c, 9'h0ce:         info = op_row(SZ_QUAD, SZ_NONE, SZ_DBL,  TT_QUADOP, 1'b0, 1'b0);
        9'h0c7, 9'h0d3:         info = op_row(SZ_SGL,  SZ_NONE, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h0cb:                 info = op_row(SZ_DBL,  SZ_NONE, SZ_QUAD, TT_QUADOP, 1'b0, 1'b0);
        9'h0cc, 9'h0cd:         info = op_row(SZ_QUAD, SZ_NONE, SZ_SGL,  TT_QUADOP, 1'b0, 1'b0);
        9'h029:                 info = op_row(SZ_SGL,  SZ_NONE, SZ_SGL,  TT_CLR,    1'b1, 1'b0);
        9'h02a:                 info = op_row(SZ_DBL,  SZ_NONE, SZ_DBL,  TT_CLR,    1'b1, 1'b0);
        9'h041, 9'h045,
        9'h049, 9'h04d:         info = op_row(SZ_SGL,  SZ_SGL,  SZ_SGL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h042, 9'h046,
        9'h04a, 9'h04e:         info = op_row(SZ_DBL,  SZ_DBL,  SZ_DBL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h069:                 info = op_row(SZ_DBL,  SZ_SGL,  SZ_SGL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h081, 9'h0c9, 9'h0c8: info = op_row(SZ_DBL,  SZ_NONE, SZ_SGL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h082, 9'h088:         info = op_row(SZ_DBL,  SZ_NONE, SZ_DBL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h0c6, 9'h0d2, 9'h084: info = op_row(SZ_SGL,  SZ_NONE, SZ_DBL,  TT_SUBNORM, 1'b0, 1'b0);
        9'h0d1:                 info = op_row(SZ_SGL,  SZ_NONE, SZ_SGL,  TT_SUBNORM, 1'b0, 1'b0);
        default:                info = '0;
      endcase
    end else begin
      case (opf)
        9'h053, 9'h057: info = op_row(SZ_NONE, SZ_QUAD, SZ_QUAD, TT_QUADOP, 1'b0, 1'b1);
        default:        info = '0;
      endcase
    end
  end

endmodule

// File: rtl/fpdec_regmap.sv
module fpdec_regmap
  import fpdec_pkg::*;
#(
  parameter int FLD_W = 5,
  localparam int IDX_W = FLD_W + 1
) (
  input  logic [FLD_W-1:0] spec,
  input  opnd_size_e       size,
  output logic [IDX_W-1:0] idx,
  output logic             misaligned
);

  always_comb begin
    case (size)
      SZ_SGL:          idx = {1'b0, spec};
      SZ_DBL, SZ_QUAD: idx = {spec[0], spec[FLD_W-1:1], 1'b0};
      default:         idx = '0;
    endcase
    misaligned = (size == SZ_QUAD) && spec[1];
  end

endmodule

// File: rtl/fp_opdecode.sv
module fp_opdecode
  import fpdec_pkg::*;
#(
  parameter int FLD_W = 5,
  parameter int OPF_W = 9,
  parameter int TT_W  = 3,
  localparam int IDX_W = FLD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [TT_W-1:0]  tt_in,
  input  logic             via_illegal,
  input  logic [1:0]       bank_dirty,
  output logic             out_valid,
  output logic [2:0]       err_code,
  output logic             is_fmt2,
  output logic [OPF_W-1:0] opf,
  output logic [TT_W-1:0]  tt_out,
  output logic [1:0]       rd_size,
  output logic [1:0]       rs1_size,
  output logic [1:0]       rs2_size,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] rs1_idx,
  output logic [IDX_W-1:0] rs2_idx,
  output logic             rs1_zero,
  output logic             rs2_zero,
  output logic             cc_dest,
  output logic [1:0]       cc_sel
);

  localparam int          NOPND    = 3;
  localparam int          RD_LSB   = 25;
  localparam int          RS1_LSB  = 14;
  localparam int          OPF_LSB  = 5;
  localparam int          RS2_LSB  = 0;
  localparam logic [31:0] FMT_MASK = 32'hC1F8_0000;
  localparam logic [31:0] FMT1_VAL = 32'h81A0_0000;
  localparam logic [31:0] FMT2_VAL = 32'h81A8_0000;

  // reset released synchronously
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  // format and op lookup
  logic             fmt1_hit, fmt2_hit;
  logic [OPF_W-1:0] opf_f;
  op_info_t         info;

  assign fmt1_hit = (insn & FMT_MASK) == FMT1_VAL;
  assign fmt2_hit = (insn & FMT_MASK) == FMT2_VAL;
  assign opf_f    = insn[OPF_LSB +: OPF_W];

  fpdec_opmap #(.OPF_W(OPF_W)) u_opmap (
    .is_fmt2 (fmt2_hit),
    .opf     (opf_f),
    .info    (info)
  );

  // operand mapping, slot 0 = rd, 1 = rs1, 2 = rs2
  logic [FLD_W-1:0] spec   [NOPND];
  opnd_size_e       sz     [NOPND];
  logic [IDX_W-1:0] idx    [NOPND];
  logic [NOPND-1:0] mis;

  assign spec[0] = insn[RD_LSB  +: FLD_W];
  assign spec[1] = insn[RS1_LSB +: FLD_W];
  assign spec[2] = insn[RS2_LSB +: FLD_W];
  assign sz[0]   = info.rd_sz;
  assign sz[1]   = info.rs1_sz;
  assign sz[2]   = info.rs2_sz;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fpdec_regmap #(.FLD_W(FLD_W)) u_map (
      .spec       (spec[g]),
      .size       (sz[g]),
      .idx        (idx[g]),
      .misaligned (mis[g])
    );
  end

  // next-state decision
  dec_err_e         err_n;
  logic             ok_n;
  logic             class_ok;
  logic [TT_W-1:0]  tt_n;
  opnd_size_e       sz_n   [NOPND];
  logic [IDX_W-1:0] idx_n  [NOPND];
  logic             z1_n, z2_n, cc_n;
  logic [1:0]       ccs_n;

  always_comb begin
    class_ok = via_illegal || info.any_tt || (tt_in == TT_W'(info.want_tt));
    if (!(fmt1_hit || fmt2_hit))  err_n = ERR_NOT_FPOP;
    else if (!info.known)         err_n = ERR_BAD_OPF;
    else if (!class_ok)           err_n = ERR_CLASS;
    else if (|mis)                err_n = ERR_BAD_REG;
    else                          err_n = ERR_NONE;
    ok_n = (err_n == ERR_NONE);

    case (err_n)
      ERR_NONE:    tt_n = TT_W'(TT_CLR);
      ERR_BAD_REG: tt_n = TT_W'(TT_BADREG);
      default:     tt_n = tt_in;
    endcase

    for (int i = 0; i < NOPND; i++) begin
      sz_n[i]  = ok_n ? sz[i]  : SZ_NONE;
      idx_n[i] = ok_n ? idx[i] : '0;
    end
    z1_n  = ok_n && (sz[1] != SZ_NONE) && !bank_dirty[idx[1][IDX_W-1]];
    z2_n  = ok_n && (sz[2] != SZ_NONE) && !bank_dirty[idx[2][IDX_W-1]];
    cc_n  = ok_n && info.cmp;
    ccs_n = cc_n ? spec[0][1:0] : 2'b00;
  end

  // result registers
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      out_valid <= 1'b0;
      err_code  <= 3'd0;
      is_fmt2   <= 1'b0;
      opf       <= '0;
      tt_out    <= '0;
      rd_size   <= 2'd0;
      rs1_size  <= 2'd0;
      rs2_size  <= 2'd0;
      rd_idx    <= '0;
      rs1_idx   <= '0;
      rs2_idx   <= '0;
      rs1_zero  <= 1'b0;
      rs2_zero  <= 1'b0;
      cc_dest   <= 1'b0;
      cc_sel    <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        err_code  <= err_n;
        is_fmt2   <= fmt2_hit;
        opf       <= opf_f;
        tt_out    <= tt_n;
        rd_size   <= sz_n[0];
        rs1_size  <= sz_n[1];
        rs2_size  <= sz_n[2];
        rd_idx    <= idx_n[0];
        rs1_idx   <= idx_n[1];
        rs2_idx   <= idx_n[2];
        rs1_zero  <= z1_n;
        rs2_zero  <= z2_n;
        cc_dest   <= cc_n;
        cc_sel    <= ccs_n;
      end
    end
  end

endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker #(
  parameter int IDX_W = 6,
  parameter int TT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [TT_W-1:0]  tt_in,
  input logic             out_valid,
  input logic [2:0]       err_code,
  input logic [TT_W-1:0]  tt_out,
  input logic [1:0]       rd_size,
  input logic [1:0]       rs1_size,
  input logic [1:0]       rs2_size,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] rs1_idx,
  input logic [IDX_W-1:0] rs2_idx,
  input logic             rs1_zero,
  input logic             rs2_zero,
  input logic             cc_dest
);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(err_code) && $stable(tt_out) && $stable(rs2_idx)));

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_size == 2'd1) |-> !rs1_idx[IDX_W-1]);

  p_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs2_size[1] |-> !rs2_idx[0]) and (rd_size[1] |-> !rd_idx[0]));

  p_quad_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_size == 2'd3) |-> !rs1_idx[1]);

  p_badreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err_code == 3'd4) |->
      (tt_out == TT_W'(6) && rd_size == 2'd0 && rs1_size == 2'd0 && rs2_size == 2'd0));

  p_class_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err_code == 3'd3) |-> (tt_out == $past(tt_in)));

  p_ok_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err_code == 3'd0) |-> (tt_out == '0));

  p_unknown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err_code == 3'd2) |->
      (rd_size == 2'd0 && rs1_size == 2'd0 && rs2_size == 2'd0 && !cc_dest));

  p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_zero |-> rs1_size != 2'd0) and (rs2_zero |-> rs2_size != 2'd0));

  p_cmp_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cc_dest |-> (rd_size == 2'd0));

endmodule

bind fp_opdecode fpdec_checker #(.IDX_W(IDX_W), .TT_W(TT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .tt_in     (tt_in),
  .out_valid (out_valid),
  .err_code  (err_code),
  .tt_out    (tt_out),
  .rd_size   (rd_size),
  .rs1_size  (rs1_size),
  .rs2_size  (rs2_size),
  .rd_idx    (rd_idx),
  .rs1_idx   (rs1_idx),
  .rs2_idx   (rs2_idx),
  .rs1_zero  (rs1_zero),
  .rs2_zero  (rs2_zero),
  .cc_dest   (cc_dest)
);

// File: tb/fp_opdecode_bench.sv
`timescale 1ns/1ps
module fp_opdecode_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [2:0]  tt_in;
  logic        via_illegal;
  logic [1:0]  bank_dirty;
  logic        out_valid, is_fmt2, rs1_zero, rs2_zero, cc_dest;
  logic [2:0]  err_code, tt_out;
  logic [8:0]  opf;
  logic [1:0]  rd_size, rs1_size, rs2_size, cc_sel;
  logic [5:0]  rd_idx, rs1_idx, rs2_idx;

  always #2.5 clk = ~clk;

  fp_opdecode u_fp_opdecode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .tt_in(tt_in),
    .via_illegal(via_illegal), .bank_dirty(bank_dirty), .out_valid(out_valid),
    .err_code(err_code), .is_fmt2(is_fmt2), .opf(opf), .tt_out(tt_out),
    .rd_size(rd_size), .rs1_size(rs1_size), .rs2_size(rs2_size),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rs1_zero(rs1_zero), .rs2_zero(rs2_zero), .cc_dest(cc_dest), .cc_sel(cc_sel)
  );

  typedef struct packed {
    logic [1:0] kind;   // 0 format 1, 1 format 2, 2 not an operate word
    logic [8:0] opf;
    logic [4:0] rd, rs1, rs2;
    logic [2:0] tt;
    logic       ill;
    logic [1:0] dirty;
    logic [2:0] e_err, e_tt;
    logic [1:0] e_szd, e_sz1, e_sz2;
    logic [5:0] e_id, e_i1, e_i2;
    logic       e_z1, e_z2, e_cc;
    logic [1:0] e_ccs;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 9'h041,  5,  7,  9, 3'd2, 1'b0, 2'd3, 3'd0, 3'd0, 2'd1, 2'd1, 2'd1,  5,  7,  9, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h042,  3,  4, 31, 3'd2, 1'b0, 2'd1, 3'd0, 3'd0, 2'd2, 2'd2, 2'd2, 34,  4, 62, 1'b0, 1'b1, 1'b0, 2'd0},
    '{2'd0, 9'h043,  4,  8, 13, 3'd3, 1'b0, 2'd3, 3'd0, 3'd0, 2'd3, 2'd3, 2'd3,  4,  8, 44, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h043,  4,  8,  2, 3'd3, 1'b0, 2'd3, 3'd4, 3'd6, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h043,  6,  0,  0, 3'd3, 1'b0, 2'd3, 3'd4, 3'd6, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h043,  0,  0,  0, 3'd2, 1'b0, 2'd3, 3'd3, 3'd2, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h043,  0,  0,  1, 3'd2, 1'b1, 2'd3, 3'd0, 3'd0, 2'd3, 2'd3, 2'd3,  0,  0, 32, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd1, 9'h053,  2,  4,  8, 3'd3, 1'b0, 2'd3, 3'd0, 3'd0, 2'd0, 2'd3, 2'd3,  0,  4,  8, 1'b0, 1'b0, 1'b1, 2'd2},
    '{2'd0, 9'h1FF,  0,  0,  0, 3'd5, 1'b0, 2'd3, 3'd2, 3'd5, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd2, 9'h041,  0,  0,  0, 3'd3, 1'b0, 2'd3, 3'd1, 3'd3, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h029,  1,  0,  3, 3'd5, 1'b0, 2'd2, 3'd0, 3'd0, 2'd1, 2'd0, 2'd1,  1,  0,  3, 1'b0, 1'b1, 1'b0, 2'd0},
    '{2'd0, 9'h06e,  8,  1,  3, 3'd3, 1'b0, 2'd3, 3'd0, 3'd0, 2'd3, 2'd2, 2'd2,  8, 32, 34, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h0d3, 31,  0, 12, 3'd3, 1'b0, 2'd3, 3'd0, 3'd0, 2'd1, 2'd0, 2'd3, 31,  0, 12, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd1, 9'h057,  3,  4,  2, 3'd3, 1'b0, 2'd3, 3'd4, 3'd6, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd1, 9'h041,  0,  0,  0, 3'd3, 1'b0, 2'd3, 3'd2, 3'd3, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h042,  0,  0,  0, 3'd3, 1'b0, 2'd3, 3'd3, 3'd3, 2'd0, 2'd0, 2'd0,  0,  0,  0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 9'h049,  0,  4, 31, 3'd2, 1'b0, 2'd0, 3'd0, 3'd0, 2'd1, 2'd1, 2'd1,  0,  4, 31, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] kind, input logic [4:0] rd,
                                     input logic [4:0] rs1, input logic [8:0] op,
                                     input logic [4:0] rs2);
    logic [5:0] op3;
    op3 = (kind == 2'd0) ? 6'h34 : (kind == 2'd1) ? 6'h35 : 6'h00;
    return {2'b10, rd, op3, rs1, op, rs2};
  endfunction

  function automatic string err_tag(input logic [2:0] e);
    case (e)
      3'd0:    return "R7";
      3'd1:    return "R1";
      3'd2:    return "R8";
      3'd3:    return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; tt_in = '0;
    via_illegal = 1'b0; bank_dirty = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R11 reset out_valid", out_valid, 0);
    check("R7 reset err_code", err_code, 0);
    check("R7 reset tt_out", tt_out, 0);

    for (int v = 0; v < NV; v++) begin
      insn        = mk(VECS[v].kind, VECS[v].rd, VECS[v].rs1, VECS[v].opf, VECS[v].rs2);
      tt_in       = VECS[v].tt;
      via_illegal = VECS[v].ill;
      bank_dirty  = VECS[v].dirty;
      in_valid    = 1'b1;
      @(negedge clk);
      check("R11 out_valid", out_valid, 1);
      check(err_tag(VECS[v].e_err), err_code, VECS[v].e_err);
      check({err_tag(VECS[v].e_err), " tt_out"}, tt_out, VECS[v].e_tt);
      check("R1 is_fmt2", is_fmt2, VECS[v].kind == 2'd1);
      check("R2 opf", opf, VECS[v].opf);
      check("R2 rd_size", rd_size, VECS[v].e_szd);
      check("R2 rs1_size", rs1_size, VECS[v].e_sz1);
      check("R2 rs2_size", rs2_size, VECS[v].e_sz2);
      check("R3 R4 rd_idx", rd_idx, VECS[v].e_id);
      check("R3 R4 rs1_idx", rs1_idx, VECS[v].e_i1);
      check("R3 R4 rs2_idx", rs2_idx, VECS[v].e_i2);
      check("R9 rs1_zero", rs1_zero, VECS[v].e_z1);
      check("R9 rs2_zero", rs2_zero, VECS[v].e_z2);
      check("R10 cc_dest", cc_dest, VECS[v].e_cc);
      check("R10 cc_sel", cc_sel, VECS[v].e_ccs);
    end

    // hold with strobe low: last vector result must stay
    in_valid = 1'b0;
    insn     = mk(2'd0, 5'd9, 5'd9, 9'h043, 5'd9);
    tt_in    = 3'd3;
    @(negedge clk);
    check("R11 out_valid drops", out_valid, 0);
    check("R11 rs2_idx held", rs2_idx, 31);
    check("R11 err_code held", err_code, 0);
    @(negedge clk);
    check("R11 rs1_idx held", rs1_idx, 4);

    // single-cycle strobe: result one cycle later, then drops
    in_valid = 1'b1;
    insn     = mk(2'd0, 5'd1, 5'd17, 9'h04a, 5'd16);
    tt_in    = 3'd2;
    bank_dirty = 2'b10;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 strobe result", out_valid, 1);
    check("R4 rs1_idx upper", rs1_idx, 48);
    check("R4 rs2_idx lower", rs2_idx, 16);
    check("R9 rs2_zero lower clean", rs2_zero, 1);
    check("R9 rs1_zero upper dirty", rs1_zero, 0);
    @(negedge clk);
    check("R11 strobe ends", out_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule